// File: doc/BRIEF.md
# Streaming Frame CRC Checker

This block sits in a receive data path and checks each frame as it flows past, one 16-bit word per clock, without holding the frame in memory. It computes a 22-bit cyclic redundancy check over the frame's payload words. It compares that value with the check value that the sender placed in the frame's trailer. It then forwards every word after exactly one register stage. On a mismatch, an error flag is set in the frame's last word.

A frame starts on a valid word with the start marker and ends on a valid word with the end marker. The last three words of a frame are two check-value words and a final word. Everything before them is payload. Because the block cannot know that a word is a trailer word until the end marker arrives, it delays absorbing each word into the CRC by two words. When the end marker arrives, the two words it still holds are the received check value.

A saturating counter records how many frames have been flagged. A register interface elsewhere can read this counter and can zero it through a clear input.

Top module: `crc_stream_checker`

## Requirements
- R1: Every input beat (valid, start marker, end marker, data) appears on the outputs exactly one clock later. Data bits 14..0 always pass unchanged.
- R2: The CRC uses generator x^22 + x + 1. It starts at zero on every start-marked word and shifts in each payload word most significant bit first. The payload is every word of the frame except the last three. A start marker inside an open frame abandons that frame and begins a new one.
- R3: The received check value is bits 10..0 of the third-to-last word (CRC bits 21..11) followed by bits 10..0 of the second-to-last word (CRC bits 10..0). The upper bits of those two words are ignored.
- R4: On the final word of a frame, output bit 15 is the OR of input bit 15 and the mismatch result. A matching frame forwards its final word unchanged.
- R5: A frame shorter than three words is flagged as an error on its end-marked word.
- R6: Cycles with valid low are ignored by the check, so idle gaps inside a frame do not change the result.
- R7: The error counter increments by one for each flagged frame, in the same clock edge that outputs the flagged word.
- R8: The error counter saturates at all ones.
- R9: A high clear input zeroes the counter at the next edge and takes priority over a simultaneous increment.
- R10: Any single-bit error in the payload of a frame of up to 400 words is flagged.
- R11: Valid words outside an open frame, including an end-marked one, pass unchanged and are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_data | input | DATA_W | Input data word |
| cnt_clr | input | 1 | Zero the error counter |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Delayed start marker |
| out_eof | output | 1 | Delayed end marker |
| out_data | output | DATA_W | Forwarded word, error flag in bit DATA_W-1 of the final word |
| err_count | output | CNT_W | Saturating count of flagged frames |

## Verification
On every cycle, the assertions check the one-stage alignment of valid, markers and the lower data bits. They also check that the flag bit is untouched on all but final words, and that the counter moves by at most one, stays put once saturated and zeroes on clear. Only the bench's scenarios can show whether the flag decision is right. These include the exhaustive single-bit flips over a short payload, the flips in 400-word frames, frames with gaps, short frames, restarted frames and words outside any frame, all compared against a CRC computed independently in the bench.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

  // Shift one data word into a CRC state, most significant bit first.
  function automatic logic [63:0] crc_update(input logic [63:0] state,
                                             input logic [63:0] word,
                                             input int unsigned crc_w,
                                             input int unsigned data_w,
                                             input logic [63:0] poly);
    logic [63:0] c;
    logic [63:0] mask;
    logic        fb;
    mask = (crc_w >= 64) ? '1 : ((64'd1 << crc_w) - 64'd1);
    c = state & mask;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(data_w)) begin
        fb = c[crc_w-1] ^ word[i];
        c  = (c << 1) & mask;
        if (fb) c = c ^ (poly & mask);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/crcchk_tracker.sv
module crcchk_tracker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 22,
  parameter logic [CRC_W-1:0] POLY = 22'h000003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              bad
);
  localparam int unsigned HALF_W = CRC_W / 2;

  logic              in_frame;
  logic [1:0]        held;
  logic [DATA_W-1:0] h1, h2;
  logic [CRC_W-1:0]  crc, crc_nx, rx;
  logic              frame_open, too_short;

  always_comb begin
    crc_nx     = CRC_W'(crcchk_pkg::crc_update(64'(crc), 64'(h2), CRC_W, DATA_W, 64'(POLY)));
    rx         = {h2[HALF_W-1:0], h1[HALF_W-1:0]};
    frame_open = in_sof | in_frame;
    too_short  = in_sof | (held != 2'd2);
    bad        = in_valid & in_eof & frame_open & (too_short | (crc != rx));
  end

  // Two-word hold line: a word enters the CRC only once two newer words exist.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      held     <= 2'd0;
      h1       <= '0;
      h2       <= '0;
      crc      <= '0;
    end else if (in_valid) begin
      if (in_sof) begin
        in_frame <= ~in_eof;
        held     <= 2'd1;
        crc      <= '0;
        h1       <= in_data;
      end else if (in_frame) begin
        if (in_eof) begin
          in_frame <= 1'b0;
        end else begin
          if (held == 2'd2) crc <= crc_nx;
          else              held <= held + 2'd1;
          h2 <= h1;
          h1 <= in_data;
        end
      end
    end
  end
endmodule

// File: rtl/crcchk_errcnt.sv
module crcchk_errcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)                 count <= '0;
    else if (inc && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/crcchk_outreg.sv
module crcchk_outreg #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FLAG_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bad,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_sof;
      out_eof   <= in_eof;
      out_data  <= bad ? (in_data | FLAG_MASK) : in_data;
    end
  end
endmodule

// File: rtl/crc_stream_checker.sv
module crc_stream_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 22,
  parameter logic [CRC_W-1:0] POLY = 22'h000003,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cnt_clr,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  err_count
);
  logic bad;

  crcchk_tracker #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .bad(bad)
  );

  crcchk_outreg #(.DATA_W(DATA_W), .FLAG_BIT(DATA_W - 1)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .bad(bad),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data)
  );

  crcchk_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(bad), .count(err_count)
  );
endmodule

// File: rtl/crcchk_props.sv
module crcchk_props #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              cnt_clr,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eof,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  err_count
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));
  // R1
  marker_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sof == $past(in_sof)) && (out_eof == $past(in_eof)));
  // R1
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data[DATA_W-2:0] == $past(in_data[DATA_W-2:0])));
  // R4
  flag_only_final_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_eof) |=> (out_data[DATA_W-1] == $past(in_data[DATA_W-1])));
  // R4
  flag_never_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[DATA_W-1]) |=> out_data[DATA_W-1]);
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));
  // R7
  count_needs_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !(in_valid && in_eof)) |=> $stable(err_count));
  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && (err_count == '1)) |=> (err_count == '1));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (err_count == '0));
endmodule

bind crc_stream_checker crcchk_props #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_props (.*);

// File: tb/sim_crc_stream_checker.sv
module sim_crc_stream_checker;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, cnt_clr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sof, out_eof;
  logic [DW-1:0] out_data;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int fails = 0;
  bit chk_en = 1'b0;

  logic e_valid = 1'b0, e_sof = 1'b0, e_eof = 1'b0;
  logic [DW-1:0] e_data = '0;
  int e_cnt = 0;
  string e_tag = "R1";
  bit clr_req = 1'b0;

  logic [15:0] pay [0:399];
  logic [15:0] fw  [0:402];
  logic [15:0] seed = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  crc_stream_checker #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cnt_clr(cnt_clr), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data), .err_count(err_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Bit-serial CRC over a word sequence, generator x^22 + x + 1.
  function automatic logic [21:0] ref_crc(input int n, input int flip);
    logic [21:0] c = '0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = pay[k];
      if (flip >= 0 && (flip / 16) == k) w[15 - (flip % 16)] = ~w[15 - (flip % 16)];
      for (int b = 15; b >= 0; b--) begin
        logic top = c[21] ^ w[b];
        c = {c[20:0], 1'b0};
        if (top) c = c ^ 22'h000003;
      end
    end
    return c;
  endfunction

  function automatic logic [15:0] next_rand();
    seed = seed ^ (seed << 7);
    seed = seed ^ (seed >> 9);
    seed = seed ^ (seed << 8);
    return seed;
  endfunction

  // Output monitor: results latched at an edge are compared just after it.
  always @(posedge clk) begin
    #1;
    if (chk_en) begin
      check(out_valid == e_valid, "R1", "out_valid", out_valid, e_valid);
      if (e_valid) begin
        check(out_sof == e_sof && out_eof == e_eof, "R1", "markers",
              {out_sof, out_eof}, {e_sof, e_eof});
        check(out_data == e_data, e_tag, "out_data", out_data, e_data);
      end
      check(int'(err_count) == e_cnt, e_tag, "err_count", err_count, e_cnt);
    end
  end

  task automatic beat(input logic v, input logic s, input logic e,
                      input logic [15:0] d, input logic [15:0] ed,
                      input bit inc, input string tag);
    @(negedge clk);
    in_valid = v; in_sof = s; in_eof = e; in_data = d; cnt_clr = clr_req;
    e_valid = v; e_sof = s; e_eof = e; e_data = ed; e_tag = tag;
    if (clr_req) e_cnt = 0;
    else if (inc && e_cnt != (1 << CNT_W) - 1) e_cnt++;
    clr_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, "R6");
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) pay[i] = next_rand();
  endtask

  // Payload of n words, optional bit flip, optional corrupted check value,
  // optional idle gaps, optional preset flag bit on the final word.
  task automatic send_frame(input int n, input int flip, input bit bad_crc,
                            input bit gaps, input bit hibit, input string tag);
    logic [21:0] good, sent, rx;
    logic [15:0] fin, efin;
    bit fl;
    good = ref_crc(n, -1);
    sent = ref_crc(n, flip);
    rx = bad_crc ? (good ^ 22'h200000) : good;
    fl = (sent != rx);
    if (flip >= 0) check(fl, "R10", "bench flip undetected", sent, good);
    for (int k = 0; k < n; k++) begin
      fw[k] = pay[k];
      if (flip >= 0 && (flip / 16) == k) fw[k][15 - (flip % 16)] = ~fw[k][15 - (flip % 16)];
    end
    fw[n]     = {5'b10110, rx[21:11]};
    fw[n + 1] = {5'b01001, rx[10:0]};
    fin = {hibit, next_rand()[14:0]};
    efin = fl ? (fin | 16'h8000) : fin;
    for (int k = 0; k < n + 3; k++) begin
      if (k == n + 2) beat(1'b1, k == 0, 1'b1, fin, efin, fl, tag);
      else            beat(1'b1, k == 0, 1'b0, fw[k], fw[k], 1'b0, tag);
      if (gaps && (k % 2 == 1)) idle(1 + k % 3);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(err_count == '0, "R7", "reset err_count", err_count, 0);
    @(negedge clk);
    rst = 1'b0;
    chk_en = 1'b1;

    // R2 R3 R4: matching frames of several lengths, flag untouched
    fill(20);
    send_frame(0, -1, 1'b0, 1'b0, 1'b0, "R3");
    send_frame(1, -1, 1'b0, 1'b0, 1'b0, "R2");
    send_frame(5, -1, 1'b0, 1'b0, 1'b0, "R2");
    send_frame(20, -1, 1'b0, 1'b0, 1'b1, "R4");
    // R4 R7: corrupted check value flags the final word and counts
    send_frame(6, -1, 1'b1, 1'b0, 1'b0, "R4");
    send_frame(6, -1, 1'b1, 1'b0, 1'b1, "R4");
    // R6: idle gaps inside frames
    fill(9);
    send_frame(9, -1, 1'b0, 1'b1, 1'b0, "R6");
    send_frame(9, 17, 1'b0, 1'b1, 1'b0, "R6");
    idle(2);
    // R9: clear
    clr_req = 1'b1; idle(1);
    // R10 R8: every single-bit flip of an 8-word payload; count saturates
    fill(8);
    for (int b = 0; b < 128; b++) send_frame(8, b, 1'b0, 1'b0, 1'b0, "R8");
    // R9: clear together with a flagged final word wins
    fill(4);
    for (int k = 0; k < 3; k++) beat(1'b1, k == 0, 1'b0, pay[k], pay[k], 1'b0, "R9");
    clr_req = 1'b1;
    beat(1'b1, 1'b0, 1'b1, 16'h0123, 16'h8123, 1'b1, "R9");
    // R10: long frames
    fill(400);
    send_frame(400, -1, 1'b0, 1'b0, 1'b0, "R10");
    send_frame(400, 0, 1'b0, 1'b0, 1'b0, "R10");
    send_frame(400, 3200, 1'b0, 1'b0, 1'b0, "R10");
    send_frame(400, 6399, 1'b0, 1'b0, 1'b0, "R10");
    // R5: short frames
    beat(1'b1, 1'b1, 1'b1, 16'h0042, 16'h8042, 1'b1, "R5");
    beat(1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0, "R5");
    beat(1'b1, 1'b0, 1'b1, 16'h0007, 16'h8007, 1'b1, "R5");
    // R11: words outside a frame, including an end-marked one
    beat(1'b1, 1'b0, 1'b0, 16'h7777, 16'h7777, 1'b0, "R11");
    beat(1'b1, 1'b0, 1'b1, 16'h1111, 16'h1111, 1'b0, "R11");
    // R2: a start marker mid-frame restarts the check
    fill(10);
    for (int k = 0; k < 4; k++) beat(1'b1, k == 0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, "R2");
    send_frame(10, -1, 1'b0, 1'b0, 1'b0, "R2");
    idle(3);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule